// File: doc/BRIEF.md
# Direct Digital Synthesis Waveform Core

This block is a numerically controlled oscillator that produces a 10-bit DAC code and a one-bit square output from a master clock. A 28-bit phase accumulator adds a frequency word on every running cycle. A 12-bit phase offset is added to the top of the accumulator, and the sum is truncated to a 10-bit phase index. That index drives a sine lookup, a triangle ramp or a square wave. The chosen sample then passes through a fixed seven-stage output pipeline.

Configuration is written through a synchronous write port with three targets: the frequency word, the phase word and a control word. The control word holds a soft reset, a two-bit sleep field and the waveform-select bits. While the soft reset bit is set, the datapath is held cleared. When the clock-stop sleep bit is set, the accumulator and the pipeline are frozen. Register writes are still accepted during that sleep and take effect once the clock runs again.

Top module: `dds_core`

## Requirements
- R1: `wr_sel` 0 loads the 28-bit frequency word, 1 loads the 12-bit phase word from `wr_data[11:0]`, and 2 loads the control word. Control bits: bit 1 ramp, bit 3 direct-square, bit 5 square enable, bit 6 DAC path off, bit 7 clock stop, bit 8 soft reset. The write takes effect at the clock edge on which `wr_en` is sampled high.
- R2: While the soft reset bit is 1, the accumulator, the divide-by-two toggle and every pipeline stage are cleared, so `dac_code` is 0 and `sq_out` is 0.
- R3: A sample is computed from the accumulator value of one cycle and reaches the outputs exactly 7 clock edges later. After the soft reset bit is cleared at edge k, the outputs stay 0 up to edge k+6. At edge k+7 they show the waveform for accumulator value 0 plus the phase offset.
- R4: On each running cycle the accumulator grows by the frequency word, modulo 2^28. The phase index is bits [11:2] of (accumulator bits [27:16] + phase word) modulo 4096. So the sample m cycles after release uses accumulator value m*F.
- R5: With square enable 0 and ramp 0, the DAC code is a sine centred on 512. Phase index 0 gives 512, 256 gives 1023, 512 gives 512 and 768 gives 1.
- R6: With square enable 0 and ramp 1, the DAC code is a triangle. For phase index p with bit 9 clear, the code is 2*(p mod 512). With bit 9 set, the code is 2*(511 - (p mod 512)).
- R7: With square enable 1, ramp 0 and direct-square 1, `sq_out` equals bit 9 of the phase index. The DAC code is then 1023 when `sq_out` is 1 and 0 when it is 0.
- R8: With square enable 1, ramp 0 and direct-square 0, `sq_out` is a toggle that starts at 0 after reset. It inverts on each running cycle whose phase-index bit 9 is 1 when it was 0 on the previous running cycle, including that cycle's own sample.
- R9: Square enable 1 together with ramp 1 is reserved: the DAC code is 512 and `sq_out` is 0.
- R10: With the DAC-off bit set, the DAC code is held at mid-scale 512 in every mode. The square output on `sq_out` behaves as without that bit.
- R11: With the clock-stop bit set, the accumulator and pipeline do not advance and both outputs hold. Writes are still taken, and samples computed with the new settings reach the outputs 7 edges after the clock-stop bit is cleared.
- R12: The active-high synchronous `rst` input clears all three configuration words and all datapath state. The outputs are 0 during reset, and the first sample after release appears 7 edges after the last reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 frequency, 1 phase, 2 control |
| wr_data | input | 28 | Write data |
| dac_code | output | 10 | Unsigned DAC sample code |
| sq_out | output | 1 | Square-wave output |

## Verification
A write to any configuration word lands at the edge that samples it. A sample computed after edge e leaves the pipeline at edge e+7. The first valid sample therefore appears at edge k+7 after a soft-reset release at edge k, and sample m lands at edge k+7+m. The scoreboard tags each expected value with the absolute edge count at which it is due, and compares it half a cycle later on the falling edge. Across a clock-stop sleep, the edge offsets count only the running edges: the frozen stages drain first, and the first sample taken with new settings is due 7 edges after wake-up.

// File: rtl/dds_pkg.sv
package dds_pkg;

    localparam int ACC_W   = 28;
    localparam int PH_W    = 12;
    localparam int DAC_W   = 10;
    localparam int OUT_LAT = 7;
    localparam int QBITS   = DAC_W - 2;
    localparam int QN      = 1 << QBITS;

    localparam logic [DAC_W-1:0] MID_CODE  = DAC_W'(1 << (DAC_W - 1));
    localparam logic [DAC_W-1:0] FULL_CODE = '1;
    localparam int               AMP       = (1 << (DAC_W - 1)) - 1;

    // control word bit positions
    localparam int B_RAMP    = 1;
    localparam int B_DIRECT  = 3;
    localparam int B_SQEN    = 5;
    localparam int B_DACOFF  = 6;
    localparam int B_CLKSTOP = 7;
    localparam int B_SRST    = 8;

    typedef enum logic [1:0] {
        SEL_FREQ  = 2'd0,
        SEL_PHASE = 2'd1,
        SEL_CTRL  = 2'd2
    } wr_sel_e;

    typedef struct packed {
        logic srst;
        logic clk_stop;
        logic dac_off;
        logic sq_en;
        logic direct;
        logic ramp;
    } cfg_t;

    typedef struct packed {
        logic [DAC_W-1:0] code;
        logic             sq;
    } sample_t;

    function automatic logic [DAC_W-2:0] quarter_amp(input int idx);
        real r;
        r = $sin(1.5707963267948966 * real'(idx) / real'(QN)) * real'(AMP);
        return (DAC_W-1)'($rtoi(r + 0.5));
    endfunction

    function automatic logic [DAC_W-1:0] tri_code(input logic [DAC_W-1:0] p);
        return p[DAC_W-1] ? {~p[DAC_W-2:0], 1'b0} : {p[DAC_W-2:0], 1'b0};
    endfunction

endpackage

// File: rtl/dds_regs.sv
module dds_regs
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [ACC_W-1:0] wr_data,
    output logic [ACC_W-1:0] freq,
    output logic [PH_W-1:0]  phase,
    output cfg_t             cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            freq  <= '0;
            phase <= '0;
            cfg   <= '0;
        end else if (wr_en) begin
            unique case (wr_sel)
                SEL_FREQ:  freq  <= wr_data;
                SEL_PHASE: phase <= wr_data[PH_W-1:0];
                SEL_CTRL: begin
                    cfg.srst     <= wr_data[B_SRST];
                    cfg.clk_stop <= wr_data[B_CLKSTOP];
                    cfg.dac_off  <= wr_data[B_DACOFF];
                    cfg.sq_en    <= wr_data[B_SQEN];
                    cfg.direct   <= wr_data[B_DIRECT];
                    cfg.ramp     <= wr_data[B_RAMP];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dds_phase.sv
module dds_phase
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             run,
    input  logic [ACC_W-1:0] freq,
    input  logic [PH_W-1:0]  phase,
    output logic [ACC_W-1:0] acc,
    output logic [DAC_W-1:0] pidx
);

    logic [PH_W-1:0] psum;

    always_ff @(posedge clk) begin
        if (clr)      acc <= '0;
        else if (run) acc <= acc + freq;
    end

    always_comb begin
        psum = acc[ACC_W-1 -: PH_W] + phase;
        pidx = psum[PH_W-1 -: DAC_W];
    end

endmodule

// File: rtl/dds_shape.sv
module dds_shape
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             clr,
    input  logic             run,
    input  logic [DAC_W-1:0] pidx,
    input  cfg_t             cfg,
    output sample_t          wave
);

    localparam logic [QBITS:0] QN_V = (QBITS+1)'(QN);

    logic [DAC_W-2:0] qtab [QN+1];

    genvar gi;
    generate
        for (gi = 0; gi <= QN; gi++) begin : g_qtab
            assign qtab[gi] = quarter_amp(gi);
        end
    endgenerate

    logic [1:0]       quad;
    logic [QBITS:0]   qaddr;
    logic [DAC_W-2:0] amp;
    logic [DAC_W-1:0] sine;
    logic             msb, msb_prev, tog, tog_next, sq_pick;

    always_comb begin
        quad  = pidx[DAC_W-1 -: 2];
        qaddr = quad[0] ? QN_V - {1'b0, pidx[QBITS-1:0]} : {1'b0, pidx[QBITS-1:0]};
        amp   = qtab[qaddr];
        sine  = quad[1] ? MID_CODE - {1'b0, amp} : MID_CODE + {1'b0, amp};

        msb      = pidx[DAC_W-1];
        tog_next = tog ^ (msb & ~msb_prev);
        sq_pick  = cfg.direct ? msb : tog_next;

        if (cfg.sq_en && cfg.ramp) begin
            wave.code = MID_CODE;
            wave.sq   = 1'b0;
        end else if (cfg.sq_en) begin
            wave.sq   = sq_pick;
            wave.code = cfg.dac_off ? MID_CODE : (sq_pick ? FULL_CODE : '0);
        end else begin
            wave.sq   = 1'b0;
            wave.code = cfg.dac_off ? MID_CODE : (cfg.ramp ? tri_code(pidx) : sine);
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            msb_prev <= 1'b0;
            tog      <= 1'b0;
        end else if (run) begin
            msb_prev <= msb;
            tog      <= tog_next;
        end
    end

endmodule

// File: rtl/dds_core.sv
module dds_core
    import dds_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [27:0]      wr_data,
    output logic [9:0]       dac_code,
    output logic             sq_out
);

    logic [ACC_W-1:0] freq;
    logic [PH_W-1:0]  phase;
    cfg_t             cfg;
    logic [ACC_W-1:0] acc;
    logic [DAC_W-1:0] pidx;
    sample_t          stage0;
    logic             clr, run;

    assign clr = rst | cfg.srst;
    assign run = ~cfg.clk_stop;

    dds_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .freq(freq), .phase(phase), .cfg(cfg)
    );

    dds_phase u_phase (
        .clk(clk), .clr(clr), .run(run), .freq(freq), .phase(phase),
        .acc(acc), .pidx(pidx)
    );

    dds_shape u_shape (
        .clk(clk), .clr(clr), .run(run), .pidx(pidx), .cfg(cfg), .wave(stage0)
    );

    sample_t pipe [OUT_LAT];

    genvar gs;
    generate
        for (gs = 0; gs < OUT_LAT; gs++) begin : g_pipe
            always_ff @(posedge clk) begin
                if (clr)      pipe[gs] <= '0;
                else if (run) pipe[gs] <= (gs == 0) ? stage0 : pipe[(gs == 0) ? 0 : gs-1];
            end
        end
    endgenerate

    assign dac_code = pipe[OUT_LAT-1].code;
    assign sq_out   = pipe[OUT_LAT-1].sq;

endmodule

// File: rtl/dds_core_chk.sv
module dds_core_chk
    import dds_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [27:0]      wr_data,
    input cfg_t             cfg,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] freq,
    input sample_t          stage0,
    input logic [DAC_W-1:0] pidx,
    input logic [9:0]       dac_code,
    input logic             sq_out
);

    // R1
    ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_CTRL) |=>
            (cfg.ramp == $past(wr_data[B_RAMP]) && cfg.srst == $past(wr_data[B_SRST])
             && cfg.clk_stop == $past(wr_data[B_CLKSTOP])));

    // R2
    srst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg.srst) && !$past(rst)) |-> (acc == '0 && dac_code == '0 && !sq_out));

    // R4
    acc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg.srst) && !$past(cfg.clk_stop)) |->
            (acc == $past(acc) + $past(freq)));

    // R7
    direct_sq_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.sq_en && !cfg.ramp && cfg.direct) |-> (stage0.sq == pidx[DAC_W-1]));

    // R9
    reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.sq_en && cfg.ramp) |-> (stage0.code == MID_CODE && !stage0.sq));

    // R10
    dac_off_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.dac_off |-> (stage0.code == MID_CODE));

    // R11
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg.clk_stop) && !$past(cfg.srst) && !$past(rst)) |->
            ($stable(dac_code) && $stable(sq_out) && $stable(acc)));

endmodule

bind dds_core dds_core_chk u_chk (.*);

// File: tb/sim_dds_core.sv
`timescale 1ns/1ps
module sim_dds_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [27:0] wr_data = '0;
    logic [9:0]  dac_code;
    logic        sq_out;

    dds_core u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .dac_code(dac_code), .sq_out(sq_out)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         at;
        logic [9:0] dac;
        logic       sq;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   n_run = 0;
    int   n_fail = 0;
    int   last_edge = 0;
    bit   done = 1'b0;

    localparam int RAMP = 1 << 1, DIRECT = 1 << 3, SQEN = 1 << 5;
    localparam int DACOFF = 1 << 6, CLKSTOP = 1 << 7, SRST = 1 << 8;

    // monitor: compare every due item half a cycle after its edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (e.at != cyc) begin
                n_fail++;
                $display("FAIL %s: item for edge %0d missed (now %0d)", e.req, e.at, cyc);
            end else if (dac_code !== e.dac || sq_out !== e.sq) begin
                n_fail++;
                $display("FAIL %s at edge %0d: dac=%0d sq=%0b expected dac=%0d sq=%0b",
                         e.req, cyc, dac_code, sq_out, e.dac, e.sq);
            end
        end
    end

    task automatic expect_at(input int at, input int dac, input bit sq, input string req);
        exp_t e;
        e.at = at; e.dac = 10'(dac); e.sq = sq; e.req = req;
        sb.push_back(e);
    endtask

    task automatic idle_until(input int c);
        while (cyc < c) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int data);
        wr_en = 1'b1; wr_sel = sel; wr_data = 28'(data);
        @(posedge clk); #1;
        wr_en = 1'b0;
        last_edge = cyc;
    endtask

    task automatic drain();
        while (sb.size() > 0) begin
            @(posedge clk); #1;
        end
    endtask

    // reset the datapath with the given setup; returns the release edge
    task automatic restart(input int f, input int ph, input int ctrl, output int k);
        wr(2'd0, f);
        wr(2'd1, ph);
        wr(2'd2, ctrl | SRST);
        wr(2'd2, ctrl);
        k = last_edge;
    endtask

    function automatic int pidx_of(input longint m, input longint f, input int ph);
        longint a;
        a = (m * f) % (64'd1 << 28);
        return int'((((a >> 16) + ph) % 4096) >> 2);
    endfunction

    function automatic int sine_ref(input int p);
        case (p)
            0:       return 512;
            256:     return 1023;
            512:     return 512;
            default: return 1;
        endcase
    endfunction

    function automatic int tri_ref(input int p);
        return (p < 512) ? 2 * p : 2 * (511 - (p - 512));
    endfunction

    initial begin
        int k, s, w, f, p;
        bit prv, tg;

        // R12: outputs cleared during reset, first sample 7 edges after release
        repeat (4) @(posedge clk);
        #1;
        expect_at(cyc, 0, 1'b0, "R12");
        rst = 1'b0;
        k = cyc;
        expect_at(k + 6, 0, 1'b0, "R12");
        expect_at(k + 7, 512, 1'b0, "R12");
        drain();

        // R3 R5: latency after soft reset and sine at quarter points
        f = 1 << 26;
        restart(f, 0, 0, k);
        expect_at(k + 6, 0, 1'b0, "R3");
        for (int m = 0; m < 6; m++) begin
            p = pidx_of(m, f, 0);
            expect_at(k + 7 + m, sine_ref(p), 1'b0, "R5");
        end
        drain();

        // R2: soft reset held keeps outputs at zero
        wr(2'd2, SRST);
        expect_at(last_edge + 2, 0, 1'b0, "R2");
        idle_until(last_edge + 9);
        expect_at(cyc + 1, 0, 1'b0, "R2");
        drain();

        // R4: phase offset of a quarter turn shifts the sine
        restart(f, 12'h400, 0, k);
        for (int m = 0; m < 4; m++) begin
            p = pidx_of(m, f, 12'h400);
            expect_at(k + 7 + m, sine_ref(p), 1'b0, "R4");
        end
        drain();

        // R6: triangle ramp with finer step
        f = 1 << 24;
        restart(f, 0, RAMP, k);
        for (int m = 0; m < 12; m++) begin
            p = pidx_of(m, f, 0);
            expect_at(k + 7 + m, tri_ref(p), 1'b0, "R6");
        end
        drain();

        // R7: direct square
        f = 1 << 26;
        restart(f, 0, SQEN | DIRECT, k);
        for (int m = 0; m < 8; m++) begin
            p = pidx_of(m, f, 0);
            expect_at(k + 7 + m, (p >= 512) ? 1023 : 0, p >= 512, "R7");
        end
        drain();

        // R8: divided square
        f = 3 << 25;
        restart(f, 0, SQEN, k);
        prv = 1'b0; tg = 1'b0;
        for (int m = 0; m < 10; m++) begin
            bit hi;
            p = pidx_of(m, f, 0);
            hi = (p >= 512);
            if (hi && !prv) tg = ~tg;
            prv = hi;
            expect_at(k + 7 + m, tg ? 1023 : 0, tg, "R8");
        end
        drain();

        // R9: reserved select
        restart(f, 0, SQEN | RAMP, k);
        for (int m = 0; m < 3; m++) expect_at(k + 7 + m, 512, 1'b0, "R9");
        drain();

        // R10: DAC off keeps mid-scale, square unaffected; sine also mid-scale
        f = 1 << 26;
        restart(f, 0, SQEN | DIRECT | DACOFF, k);
        for (int m = 0; m < 4; m++) begin
            p = pidx_of(m, f, 0);
            expect_at(k + 7 + m, 512, p >= 512, "R10");
        end
        drain();
        restart(f, 0, DACOFF, k);
        expect_at(k + 8, 512, 1'b0, "R10");
        drain();

        // R11: clock stop freezes, writes in sleep show up after wake
        restart(f, 0, 0, k);
        expect_at(k + 7, 512, 1'b0, "R11");
        expect_at(k + 8, 1023, 1'b0, "R11");
        idle_until(k + 11);
        wr(2'd2, CLKSTOP);
        s = last_edge;
        expect_at(s, 1023, 1'b0, "R11");
        expect_at(s + 2, 1023, 1'b0, "R11");
        expect_at(s + 5, 1023, 1'b0, "R11");
        idle_until(s + 5);
        wr(2'd2, CLKSTOP | RAMP);
        expect_at(s + 8, 1023, 1'b0, "R11");
        idle_until(s + 9);
        wr(2'd2, RAMP);
        w = last_edge;
        expect_at(w + 1, 512, 1'b0, "R11");
        expect_at(w + 2, 1, 1'b0, "R11");
        expect_at(w + 6, 1, 1'b0, "R11");
        expect_at(w + 7, 0, 1'b0, "R11");
        expect_at(w + 8, 512, 1'b0, "R11");
        expect_at(w + 9, 1022, 1'b0, "R11");
        drain();

        // R1: frequency word selected by wr_sel 0 sets the step (ramp by 64 per cycle)
        restart(1 << 24, 0, RAMP, k);
        expect_at(k + 8, 128, 1'b0, "R1");
        drain();

        @(posedge clk); #1;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule